// File: doc/BRIEF.md
# Burst DMA Register Redirection Controller

This block lets a DMA engine refresh a scattered set of registers through one fixed write address. Six selection masks hold one bit for each target register. Software sets the bits of the registers that a burst should update. A trigger starts a walk over every mask bit in a fixed order. Each set bit raises one DMA request. The DMA engine answers with a write to the single burst data address, and the block forwards that word to the target register the bit stands for. Cleared bits are passed over without a request. The walk ends after the last selected bit, or after every bit has been examined.

The DMA side never changes its destination address. All routing happens inside the block, on a target write port made of a strobe, a target index and a data word. Writing any mask register stops a burst that is in progress and returns the walker to its start. A trigger that arrives during a burst is dropped, except during the final transfer. A trigger there is held and starts the next burst at once. A write to the burst data address while the block is idle also starts a burst, and that word goes to the first selected target.

Top module: `bdr_burst_redirect`

## Requirements
- R1: Mask register m (0 to NUM_MASKS-1) sits at bus address m, and its low MASK_W bits are written from the bus data. Bit b of mask m selects target index m*MASK_W+b. Every target write carries an index below NUM_MASKS*MASK_W.
- R2: A trigger in the idle state starts a walk at index 0. The walk raises one request for each set bit, in ascending index order. The walker examines one bit per clock. The request for the first selected index j is visible j+1 cycles after the clock edge that samples the trigger. After a transfer for index p, the request for the next selected index j is visible j-p cycles after the edge of that transfer.
- R3: While a request is high, it stays high until a write reaches the burst data address (NUM_MASKS). The clock edge of that write produces exactly one target write in the next cycle, with the data word and the index of the current bit. The request is low in that next cycle.
- R4: After the transfer for the last selected index, the block raises no further request or target write and accepts the next trigger.
- R5: When all masks are zero, a triggered burst raises no request. It returns to idle within NUM_MASKS*MASK_W cycles.
- R6: A trigger that arrives while a burst is running is discarded, whether the walker is scanning or waiting on a transfer that is not the last.
- R7: A trigger that arrives while the request for the last selected index is outstanding is accepted. This includes the cycle of that index's data write. A new burst then starts from index 0 right after the current one completes.
- R8: A write to any mask register aborts a running burst. In the next cycle the request is low, no target write occurs, and the block is idle. A mask write takes priority over a trigger in the same cycle.
- R9: A write to the burst data address while idle starts a burst. The word goes to the first selected index with no request, visible j+1 cycles after that write's edge. If no bit is set, the word is dropped.
- R10: Writes to the burst data address while no request is outstanding during a burst are ignored. Writes to the unused bus address NUM_MASKS+1 have no effect.
- R11: After reset, the request and the target write strobe are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Write address: masks at 0..NUM_MASKS-1, burst data at NUM_MASKS |
| bus_wdata | input | DATA_W | Write data |
| trig | input | 1 | Burst trigger |
| dma_req | output | 1 | DMA request for one data word |
| tgt_we | output | 1 | Target register write strobe |
| tgt_sel | output | IDX_W | Index of the target register being written |
| tgt_wdata | output | DATA_W | Data for the target register |

## Verification
The assertions assume at most one bus write per cycle. They also assume that bus address and data are meaningful only while the write strobe is high. From these they check the request and acknowledge rules: the request holds, drops after its data write, and yields exactly one target write. The bench keeps to these limits. It drives every input at the falling edge, issues a single write at a time, and writes the burst data address only when a request is visible. The exceptions are the idle-start and ignored-write cases that the requirements cover.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_WAIT = 2'd2
    } seq_st_e;
endpackage

// File: rtl/bdr_mask_bank.sv
module bdr_mask_bank #(
    parameter int NUM_MASKS = 6,
    parameter int MASK_W    = 32,
    parameter int ADDR_W    = 3,
    parameter int TOTAL     = NUM_MASKS * MASK_W,
    parameter int IDX_W     = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [MASK_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  ptr,
    output logic              bit_here,
    output logic              more_after
);
    typedef logic [MASK_W-1:0] word_t;

    word_t             mask_d [NUM_MASKS];
    word_t             mask_q [NUM_MASKS];
    logic [TOTAL-1:0]  flat;

    always_comb begin
        for (int m = 0; m < NUM_MASKS; m++) begin
            mask_d[m] = mask_q[m];
            if (wr_en && wr_addr == ADDR_W'(m)) begin
                mask_d[m] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int m = 0; m < NUM_MASKS; m++) begin
                mask_q[m] <= '0;
            end
        end else begin
            for (int m = 0; m < NUM_MASKS; m++) begin
                mask_q[m] <= mask_d[m];
            end
        end
    end

    for (genvar g = 0; g < NUM_MASKS; g++) begin : g_flat
        assign flat[g*MASK_W +: MASK_W] = mask_q[g];
    end

    assign bit_here = flat[ptr];

    always_comb begin
        more_after = 1'b0;
        for (int i = 0; i < TOTAL; i++) begin
            if (IDX_W'(i) > ptr && flat[i]) begin
                more_after = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bdr_sequencer.sv
module bdr_sequencer
    import bdr_pkg::*;
#(
    parameter int TOTAL  = 192,
    parameter int IDX_W  = $clog2(TOTAL),
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              mask_wr,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bit_here,
    input  logic              more_after,
    output logic [IDX_W-1:0]  ptr,
    output logic              dma_req,
    output logic              fire,
    output logic [IDX_W-1:0]  fire_idx,
    output logic [DATA_W-1:0] fire_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [IDX_W-1:0]  ptr;
        logic              pend;
        logic              hold_v;
        logic [DATA_W-1:0] hold_d;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_xfer, pend_now, finish;

    always_comb begin
        seq_d     = seq_q;
        fire      = 1'b0;
        fire_idx  = seq_q.ptr;
        fire_data = seq_q.hold_d;
        finish    = 1'b0;
        last_xfer = (seq_q.st == ST_WAIT) && !more_after;
        pend_now  = seq_q.pend | (trig & last_xfer);

        if (mask_wr) begin
            seq_d.st     = ST_IDLE;
            seq_d.ptr    = '0;
            seq_d.pend   = 1'b0;
            seq_d.hold_v = 1'b0;
        end else begin
            unique case (seq_q.st)
                ST_IDLE: begin
                    if (data_wr) begin
                        seq_d.st     = ST_SCAN;
                        seq_d.ptr    = '0;
                        seq_d.hold_v = 1'b1;
                        seq_d.hold_d = wdata;
                    end else if (trig) begin
                        seq_d.st  = ST_SCAN;
                        seq_d.ptr = '0;
                    end
                end
                ST_SCAN: begin
                    if (bit_here) begin
                        if (seq_q.hold_v) begin
                            fire         = 1'b1;
                            seq_d.hold_v = 1'b0;
                            if (!more_after) begin
                                finish = 1'b1;
                            end else begin
                                seq_d.ptr = seq_q.ptr + IDX_W'(1);
                            end
                        end else begin
                            seq_d.st = ST_WAIT;
                        end
                    end else if (seq_q.ptr == LAST_IDX) begin
                        finish = 1'b1;
                    end else begin
                        seq_d.ptr = seq_q.ptr + IDX_W'(1);
                    end
                end
                ST_WAIT: begin
                    seq_d.pend = pend_now;
                    if (data_wr) begin
                        fire      = 1'b1;
                        fire_data = wdata;
                        if (!more_after) begin
                            finish = 1'b1;
                        end else begin
                            seq_d.ptr = seq_q.ptr + IDX_W'(1);
                            seq_d.st  = ST_SCAN;
                        end
                    end
                end
                default: begin
                    seq_d.st = ST_IDLE;
                end
            endcase
        end

        if (finish) begin
            seq_d.st     = pend_now ? ST_SCAN : ST_IDLE;
            seq_d.ptr    = '0;
            seq_d.pend   = 1'b0;
            seq_d.hold_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, ptr: '0, pend: 1'b0, hold_v: 1'b0, hold_d: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ptr     = seq_q.ptr;
    assign dma_req = (seq_q.st == ST_WAIT);
endmodule

// File: rtl/bdr_write_route.sv
module bdr_write_route #(
    parameter int NUM_MASKS = 6,
    parameter int ADDR_W    = 3,
    parameter int IDX_W     = 8,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              fire,
    input  logic [IDX_W-1:0]  fire_idx,
    input  logic [DATA_W-1:0] fire_data,
    output logic              mask_wr,
    output logic              data_wr,
    output logic              tgt_we,
    output logic [IDX_W-1:0]  tgt_sel,
    output logic [DATA_W-1:0] tgt_wdata
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(NUM_MASKS);

    typedef struct packed {
        logic              we;
        logic [IDX_W-1:0]  sel;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        mask_wr  = bus_we && (bus_addr < DATA_ADDR);
        data_wr  = bus_we && (bus_addr == DATA_ADDR);
        out_d    = out_q;
        out_d.we = fire;
        if (fire) begin
            out_d.sel  = fire_idx;
            out_d.data = fire_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign tgt_we    = out_q.we;
    assign tgt_sel   = out_q.sel;
    assign tgt_wdata = out_q.data;
endmodule

// File: rtl/bdr_burst_redirect.sv
module bdr_burst_redirect #(
    parameter int NUM_MASKS = 6,
    parameter int MASK_W    = 32,
    parameter int DATA_W    = 32,
    localparam int TOTAL    = NUM_MASKS * MASK_W,
    localparam int IDX_W    = $clog2(TOTAL),
    localparam int ADDR_W   = $clog2(NUM_MASKS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              trig,
    output logic              dma_req,
    output logic              tgt_we,
    output logic [IDX_W-1:0]  tgt_sel,
    output logic [DATA_W-1:0] tgt_wdata
);
    logic              mask_wr, data_wr;
    logic              bit_here, more_after;
    logic [IDX_W-1:0]  ptr;
    logic              fire;
    logic [IDX_W-1:0]  fire_idx;
    logic [DATA_W-1:0] fire_data;

    bdr_write_route #(
        .NUM_MASKS(NUM_MASKS), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_route (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .fire(fire), .fire_idx(fire_idx), .fire_data(fire_data),
        .mask_wr(mask_wr), .data_wr(data_wr),
        .tgt_we(tgt_we), .tgt_sel(tgt_sel), .tgt_wdata(tgt_wdata)
    );

    bdr_mask_bank #(
        .NUM_MASKS(NUM_MASKS), .MASK_W(MASK_W), .ADDR_W(ADDR_W),
        .TOTAL(TOTAL), .IDX_W(IDX_W)
    ) u_masks (
        .clk(clk), .rst_n(rst_n), .wr_en(mask_wr), .wr_addr(bus_addr),
        .wr_data(bus_wdata[MASK_W-1:0]), .ptr(ptr),
        .bit_here(bit_here), .more_after(more_after)
    );

    bdr_sequencer #(
        .TOTAL(TOTAL), .IDX_W(IDX_W), .DATA_W(DATA_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .trig(trig), .mask_wr(mask_wr),
        .data_wr(data_wr), .wdata(bus_wdata), .bit_here(bit_here),
        .more_after(more_after), .ptr(ptr), .dma_req(dma_req),
        .fire(fire), .fire_idx(fire_idx), .fire_data(fire_data)
    );
endmodule

// File: rtl/bdr_checker.sv
module bdr_checker #(
    parameter int NUM_MASKS = 6,
    parameter int TOTAL     = 192,
    parameter int IDX_W     = 8,
    parameter int ADDR_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              dma_req,
    input logic              tgt_we,
    input logic [IDX_W-1:0]  tgt_sel
);
    logic wr_burst, wr_mask;
    assign wr_burst = bus_we && (bus_addr == ADDR_W'(NUM_MASKS));
    assign wr_mask  = bus_we && (bus_addr < ADDR_W'(NUM_MASKS));

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && !bus_we |=> dma_req); // R3
    AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && wr_burst |=> !dma_req); // R3
    AST_ONE_WRITE_PER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && wr_burst |=> tgt_we); // R3
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && !wr_burst |=> !tgt_we); // R3
    AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> !dma_req && !tgt_we); // R8
    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_we |-> tgt_sel <= IDX_W'(TOTAL - 1)); // R1
endmodule

bind bdr_burst_redirect bdr_checker #(
    .NUM_MASKS(NUM_MASKS), .TOTAL(TOTAL), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .dma_req(dma_req), .tgt_we(tgt_we), .tgt_sel(tgt_sel)
);

// File: tb/sim_bdr_burst_redirect.sv
module sim_bdr_burst_redirect;
    localparam int NM    = 6;
    localparam int MW    = 4;
    localparam int TOTAL = NM * MW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        trig = 1'b0;
    logic        dma_req, tgt_we;
    logic [4:0]  tgt_sel;
    logic [31:0] tgt_wdata;

    int n_chk = 0;
    int n_fail = 0;

    bdr_burst_redirect #(.NUM_MASKS(NM), .MASK_W(MW), .DATA_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .trig(trig), .dma_req(dma_req),
        .tgt_we(tgt_we), .tgt_sel(tgt_sel), .tgt_wdata(tgt_wdata)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic set_masks(input logic [TOTAL-1:0] m);
        for (int i = 0; i < NM; i++) begin
            bus_we = 1'b1; bus_addr = 3'(i); bus_wdata = {28'h0, m[i*MW +: MW]};
            @(negedge clk);
        end
        bus_we = 1'b0;
    endtask

    task automatic wait_req(input int start_k, input int expk, input string rq);
        int k;
        k = start_k;
        while (!dma_req && k < TOTAL + 2) begin
            @(negedge clk);
            k++;
        end
        chk(dma_req && k == expk, rq, k, expk);
    endtask

    task automatic do_write(input int j, input int tag);
        logic [31:0] d;
        d = 32'hA500_0000 ^ (32'(tag) << 8) ^ 32'(j);
        bus_we = 1'b1; bus_addr = 3'd6; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; trig = 1'b0;
        chk(tgt_we && tgt_sel == 5'(j), "R1", tgt_sel, j);
        chk(tgt_wdata == d, "R3", tgt_wdata, d);
        chk(!dma_req, "R3", dma_req, 0);
    endtask

    task automatic quiet(input string rq);
        bit bad;
        bad = 1'b0;
        repeat (TOTAL + 2) begin
            @(negedge clk);
            if (dma_req || tgt_we) bad = 1'b1;
        end
        chk(!bad, rq, bad, 0);
    endtask

    task automatic run_burst(input logic [TOTAL-1:0] m, input int tag, input bit by_data, input string qtag);
        int prev, k;
        bit first;
        logic [31:0] hd;
        prev = -1; first = 1'b1;
        hd = 32'h5EED_0000 | 32'(tag);
        if (by_data) begin
            bus_we = 1'b1; bus_addr = 3'd6; bus_wdata = hd;
        end else begin
            trig = 1'b1;
        end
        @(negedge clk);
        bus_we = 1'b0; trig = 1'b0;
        for (int j = 0; j < TOTAL; j++) begin
            if (m[j]) begin
                if (by_data && first) begin
                    k = 0;
                    while (!tgt_we && k < TOTAL + 2) begin
                        @(negedge clk);
                        k++;
                    end
                    chk(tgt_we && tgt_sel == 5'(j) && tgt_wdata == hd && k == j + 1, "R9", k, j + 1);
                    chk(!dma_req, "R9", dma_req, 0);
                end else begin
                    wait_req(0, j - prev, "R2");
                    do_write(j, tag);
                end
                prev = j; first = 1'b0;
            end
        end
        quiet(qtag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R4 watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] x;
        logic [TOTAL-1:0] m;
        repeat (3) @(negedge clk);
        chk(!dma_req && !tgt_we, "R11", {dma_req, tgt_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dma_req && !tgt_we, "R11", {dma_req, tgt_we}, 0);

        // R2 R3 R4 R9: sweep of mask patterns
        x = 32'h1234_5678;
        for (int t = 0; t < 40; t++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            m = x[TOTAL-1:0];
            if (t % 5 == 1) m = m & {x[7:0], x[15:0]};
            if (t == 7) m = '0;
            set_masks(m);
            run_burst(m, t, (t % 4 == 2), (m == '0) ? ((t % 4 == 2) ? "R9" : "R5") : "R4");
        end

        // R5: all-zero masks, then R9 dropped idle data, then all ones
        set_masks('0);
        run_burst('0, 100, 1'b0, "R5");
        run_burst('0, 101, 1'b1, "R9");
        set_masks('1);
        run_burst('1, 102, 1'b0, "R4");

        // R6: triggers during scan and during a non-final transfer are dropped
        m = '0; m[3] = 1'b1; m[10] = 1'b1; m[17] = 1'b1;
        set_masks(m);
        trig = 1'b1; @(negedge clk);
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        wait_req(1, 4, "R2");
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        chk(dma_req && !tgt_we, "R6", dma_req, 1);
        do_write(3, 110);
        wait_req(0, 7, "R2");
        do_write(10, 110);
        wait_req(0, 7, "R2");
        do_write(17, 110);
        quiet("R6");

        // R7: trigger during final transfer restarts at once
        m = '0; m[2] = 1'b1; m[5] = 1'b1;
        set_masks(m);
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        wait_req(0, 3, "R2");
        do_write(2, 120);
        wait_req(0, 3, "R2");
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        chk(dma_req, "R7", dma_req, 1);
        do_write(5, 120);
        wait_req(0, 3, "R7");
        do_write(2, 121);
        wait_req(0, 3, "R2");
        trig = 1'b1;
        do_write(5, 121);
        wait_req(0, 3, "R7");
        do_write(2, 122);
        wait_req(0, 3, "R2");
        do_write(5, 122);
        quiet("R4");

        // R8: mask write aborts a burst; mask write beats trigger
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        wait_req(0, 3, "R2");
        bus_we = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h0;
        @(negedge clk); bus_we = 1'b0;
        chk(!dma_req && !tgt_we, "R8", {dma_req, tgt_we}, 0);
        quiet("R8");
        trig = 1'b1; bus_we = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h0;
        @(negedge clk); trig = 1'b0; bus_we = 1'b0;
        quiet("R8");
        run_burst(m, 130, 1'b0, "R8");

        // R10: data writes with no request pending, and the spare address
        m = '0; m[20] = 1'b1;
        set_masks(m);
        trig = 1'b1; @(negedge clk); trig = 1'b0;
        bus_we = 1'b1; bus_addr = 3'd6; bus_wdata = 32'hDEAD_0001;
        @(negedge clk);
        chk(!tgt_we, "R10", tgt_we, 0);
        bus_wdata = 32'hDEAD_0002;
        @(negedge clk);
        chk(!tgt_we, "R10", tgt_we, 0);
        bus_addr = 3'd7;
        @(negedge clk); bus_we = 1'b0;
        chk(!tgt_we, "R10", tgt_we, 0);
        wait_req(3, 21, "R10");
        bus_we = 1'b1; bus_addr = 3'd7; bus_wdata = 32'hDEAD_0003;
        @(negedge clk); bus_we = 1'b0;
        chk(dma_req && !tgt_we, "R10", {dma_req, tgt_we}, 2);
        do_write(20, 140);
        quiet("R4");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule